// File: doc/BRIEF.md
# Four-Lane Vector FIR Filter

This block filters a stream of complex samples that arrives four at a time. Each accepted input vector carries four consecutive samples, and for each one the block returns one filtered sample. All four outputs of a vector leave together in one output vector. The filter is an ordinary convolution, y[n] = sum over k of h[k]·x[n-k], with complex taps h[k]. Every tap is applied the same way to all four lanes.

The samples each tap needs can fall in the vector before the current one, or further back. These older samples are not moved through a serial delay line. The block keeps the last few accepted vectors in registers. For each tap it forms a shifted four-lane window by joining the high lanes of the stored vectors with the low lanes of the current vector. With the default of eight taps, two stored vectors are kept.

The tap set is loaded through a one-word write port. A coefficient write takes effect for vectors accepted after it.

Top module: `fir4_vec_filter`

## Requirements
- R1: After reset, out_valid is 0, both output buses are 0 and the stored history is zero. The first vector's outputs therefore treat every sample before index 0 as zero.
- R2: Lane l of a vector occupies bits [l*16 +: 16] of each bus, and lane 0 is the oldest sample. Tap 0 multiplies the current vector lane for lane.
- R3: Tap k for output lane l uses the sample k positions earlier. When that sample lies before lane 0, it is taken from the high lanes of the previous accepted vector; for example, tap 1 feeds lane 0 from lane 3 of the previous vector.
- R4: With 8 taps, samples up to 7 positions back are reached, which spans two earlier vectors (tap 7 on lane 0 reads lane 1 of the vector two before).
- R5: A tap is a complex coefficient (real and imaginary, 16-bit signed, scaled by 2^-15) applied identically to all four lanes with a full complex multiply.
- R6: The history advances only when in_valid is 1. Cycles without in_valid change neither the history nor the output buses.
- R7: out_valid is 1 exactly two clock edges after an edge that sampled in_valid at 1, and 0 otherwise.
- R8: Each lane sum is rounded to the output scale by adding 2^14 and arithmetically shifting right by 15 (ties go toward plus infinity).
- R9: Rounded results outside the 16-bit signed range saturate to 32767 or -32768.
- R10: A write with coef_we at 1 loads tap coef_addr from coef_re/coef_im at the clock edge. After reset all taps are zero until written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector present this cycle |
| in_re | input | 64 | Real parts of four samples, lane 0 oldest |
| in_im | input | 64 | Imaginary parts of four samples |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 3 | Tap index written |
| coef_re | input | 16 | Real part of written tap |
| coef_im | input | 16 | Imaginary part of written tap |
| out_valid | output | 1 | Output vector present this cycle |
| out_re | output | 64 | Real parts of four filtered samples |
| out_im | output | 64 | Imaginary parts of four filtered samples |

## Verification
The bench isolates single taps at delay 1 and delay 7. A design that takes the wrong stored vector, or a lane off by one across a vector boundary, then gives visibly shifted outputs. Random idle gaps between vectors would expose a history that advances on idle cycles, because the delayed taps would read stale or skipped samples. Inputs of ±1 at half gain land exactly on the rounding ties. Full-scale inputs summed over all taps force saturation in both directions. A truncating or wrapping design would miss by one or flip sign. The first vector after reset is sent with only delayed taps loaded, so any residue in the history or in tap 0 shows up in the output.

// File: rtl/fir4_pkg.sv
package fir4_pkg;

  localparam int unsigned DEF_LANES = 4;
  localparam int unsigned DEF_DW    = 16;
  localparam int unsigned DEF_CW    = 16;
  localparam int unsigned DEF_TAPS  = 8;

  // Number of stored vectors needed to reach back TAPS-1 samples.
  function automatic int unsigned hist_vectors(input int unsigned taps,
                                               input int unsigned lanes);
    int unsigned n;
    n = (taps + lanes - 2) / lanes;
    if (n == 0) n = 1;
    return n;
  endfunction

endpackage

// File: rtl/fir4_coef_bank.sv
module fir4_coef_bank #(
  parameter int unsigned TAPS = 8,
  parameter int unsigned CW   = 16,
  parameter int unsigned AW   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [CW-1:0]      wr_re_i,
  input  logic [CW-1:0]      wr_im_i,
  output logic [TAPS*CW-1:0] tap_re_o,
  output logic [TAPS*CW-1:0] tap_im_o
);

  logic [CW-1:0] tap_re_q [TAPS];
  logic [CW-1:0] tap_im_q [TAPS];
  logic [CW-1:0] tap_re_n [TAPS];
  logic [CW-1:0] tap_im_n [TAPS];

  always_comb begin
    for (int k = 0; k < TAPS; k++) begin
      if (wr_en_i && (wr_addr_i == AW'(k))) begin
        tap_re_n[k] = wr_re_i;
        tap_im_n[k] = wr_im_i;
      end else begin
        tap_re_n[k] = tap_re_q[k];
        tap_im_n[k] = tap_im_q[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) begin
        tap_re_q[k] <= '0;
        tap_im_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < TAPS; k++) begin
        tap_re_q[k] <= tap_re_n[k];
        tap_im_q[k] <= tap_im_n[k];
      end
    end
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_flat
    assign tap_re_o[k*CW +: CW] = tap_re_q[k];
    assign tap_im_o[k*CW +: CW] = tap_im_q[k];
  end

  // R10: a write lands in the addressed tap on the next edge
  assert_coef_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (32'(wr_addr_i) < TAPS)) |=>
      (tap_re_q[$past(wr_addr_i)] == $past(wr_re_i)) &&
      (tap_im_q[$past(wr_addr_i)] == $past(wr_im_i)));

endmodule

// File: rtl/fir4_window.sv
module fir4_window #(
  parameter int unsigned LANES = 4,
  parameter int unsigned DW    = 16,
  parameter int unsigned TAPS  = 8,
  parameter int unsigned HIST  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv_i,
  input  logic [LANES*DW-1:0]      cur_re_i,
  input  logic [LANES*DW-1:0]      cur_im_i,
  output logic [TAPS*LANES*DW-1:0] win_re_o,
  output logic [TAPS*LANES*DW-1:0] win_im_o
);

  localparam int unsigned VW   = LANES * DW;
  localparam int unsigned HW   = HIST * VW;
  localparam int unsigned EXTN = (HIST + 1) * LANES;

  // Stored vectors: slot 0 is the most recent accepted vector.
  logic [HW-1:0] hist_re_q, hist_im_q;
  logic [HW-1:0] hist_re_sh, hist_im_sh;
  logic [HW-1:0] hist_re_n, hist_im_n;

  for (genvar h = 0; h < HIST; h++) begin : g_shift
    if (h == 0) begin : g_head
      assign hist_re_sh[0 +: VW] = cur_re_i;
      assign hist_im_sh[0 +: VW] = cur_im_i;
    end else begin : g_body
      assign hist_re_sh[h*VW +: VW] = hist_re_q[(h-1)*VW +: VW];
      assign hist_im_sh[h*VW +: VW] = hist_im_q[(h-1)*VW +: VW];
    end
  end

  always_comb begin
    hist_re_n = hist_re_q;
    hist_im_n = hist_im_q;
    if (adv_i) begin
      hist_re_n = hist_re_sh;
      hist_im_n = hist_im_sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_re_q <= '0;
      hist_im_q <= '0;
    end else begin
      hist_re_q <= hist_re_n;
      hist_im_q <= hist_im_n;
    end
  end

  // Extended sample line, oldest sample at index 0, current vector on top.
  logic [EXTN*DW-1:0] ext_re, ext_im;

  for (genvar e = 0; e < HIST*LANES; e++) begin : g_ext
    localparam int unsigned SLOT = HIST - 1 - (e / LANES);
    localparam int unsigned LN   = e % LANES;
    assign ext_re[e*DW +: DW] = hist_re_q[(SLOT*LANES + LN)*DW +: DW];
    assign ext_im[e*DW +: DW] = hist_im_q[(SLOT*LANES + LN)*DW +: DW];
  end
  assign ext_re[HW +: VW] = cur_re_i;
  assign ext_im[HW +: VW] = cur_im_i;

  // Window for tap k: lane l reads sample k positions earlier.
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int SRC = int'(HIST*LANES) + l - k;
      assign win_re_o[(k*LANES + l)*DW +: DW] = ext_re[SRC*DW +: DW];
      assign win_im_o[(k*LANES + l)*DW +: DW] = ext_im[SRC*DW +: DW];
    end
  end

  // R6: idle cycles leave the stored vectors untouched
  assert_hist_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(hist_re_q) && $stable(hist_im_q));

  // R3: an accepted vector becomes the most recent stored vector
  assert_hist_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> (hist_re_q[VW-1:0] == $past(cur_re_i)) &&
              (hist_im_q[VW-1:0] == $past(cur_im_i)));

endmodule

// File: rtl/fir4_cmul.sv
module fir4_cmul #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned PW = DW + CW + 1
) (
  input  logic signed [DW-1:0] a_re_i,
  input  logic signed [DW-1:0] a_im_i,
  input  logic signed [CW-1:0] c_re_i,
  input  logic signed [CW-1:0] c_im_i,
  output logic signed [PW-1:0] p_re_o,
  output logic signed [PW-1:0] p_im_o
);

  logic signed [PW-1:0] ar, ai, cr, ci;

  assign ar = PW'(a_re_i);
  assign ai = PW'(a_im_i);
  assign cr = PW'(c_re_i);
  assign ci = PW'(c_im_i);

  assign p_re_o = (ar * cr) - (ai * ci);
  assign p_im_o = (ar * ci) + (ai * cr);

endmodule

// File: rtl/fir4_lane_out.sv
module fir4_lane_out #(
  parameter int unsigned TAPS = 8,
  parameter int unsigned PW   = 33,
  parameter int unsigned DW   = 16,
  parameter int unsigned CW   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic [TAPS*PW-1:0] prod_re_i,
  input  logic [TAPS*PW-1:0] prod_im_i,
  output logic [DW-1:0]      y_re_o,
  output logic [DW-1:0]      y_im_o
);

  localparam int unsigned SW = PW + $clog2(TAPS) + 1;
  localparam logic signed [SW-1:0] RND  = SW'(1) <<< (CW - 2);
  localparam logic signed [SW-1:0] MAXV = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  function automatic logic [DW-1:0] round_sat(input logic signed [SW-1:0] acc);
    logic signed [SW-1:0] r;
    r = (acc + RND) >>> (CW - 1);
    if (r > MAXV)      return MAXV[DW-1:0];
    else if (r < MINV) return MINV[DW-1:0];
    else               return r[DW-1:0];
  endfunction

  logic signed [SW-1:0] sum_re, sum_im;
  logic [DW-1:0] y_re_q, y_im_q, y_re_n, y_im_n;

  always_comb begin
    sum_re = '0;
    sum_im = '0;
    for (int k = 0; k < TAPS; k++) begin
      sum_re = sum_re + SW'($signed(prod_re_i[k*PW +: PW]));
      sum_im = sum_im + SW'($signed(prod_im_i[k*PW +: PW]));
    end
  end

  always_comb begin
    y_re_n = y_re_q;
    y_im_n = y_im_q;
    if (en_i) begin
      y_re_n = round_sat(sum_re);
      y_im_n = round_sat(sum_im);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_re_q <= '0;
      y_im_q <= '0;
    end else begin
      y_re_q <= y_re_n;
      y_im_q <= y_im_n;
    end
  end

  assign y_re_o = y_re_q;
  assign y_im_o = y_im_q;

  // R6: outputs hold while no product set is pending
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(y_re_o) && $stable(y_im_o));

endmodule

// File: rtl/fir4_vec_filter.sv
module fir4_vec_filter
  import fir4_pkg::*;
#(
  parameter  int unsigned LANES = DEF_LANES,
  parameter  int unsigned DW    = DEF_DW,
  parameter  int unsigned CW    = DEF_CW,
  parameter  int unsigned TAPS  = DEF_TAPS,
  localparam int unsigned AW    = (TAPS > 1) ? $clog2(TAPS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [LANES*DW-1:0] in_re,
  input  logic [LANES*DW-1:0] in_im,
  input  logic                coef_we,
  input  logic [AW-1:0]       coef_addr,
  input  logic [CW-1:0]       coef_re,
  input  logic [CW-1:0]       coef_im,
  output logic                out_valid,
  output logic [LANES*DW-1:0] out_re,
  output logic [LANES*DW-1:0] out_im
);

  localparam int unsigned HIST = hist_vectors(TAPS, LANES);
  localparam int unsigned PW   = DW + CW + 1;
  localparam int unsigned WINW = TAPS * LANES * DW;
  localparam int unsigned PRW  = LANES * TAPS * PW;

  logic [TAPS*CW-1:0] tap_re, tap_im;
  logic [WINW-1:0]    win_re, win_im;
  logic [PRW-1:0]     prod_re_d, prod_im_d;
  logic [PRW-1:0]     prod_re_q, prod_im_q, prod_re_n, prod_im_n;
  logic               s1_valid_q, s1_valid_n;
  logic               out_valid_q, out_valid_n;

  fir4_coef_bank #(.TAPS(TAPS), .CW(CW), .AW(AW)) u_coef (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (coef_we),
    .wr_addr_i (coef_addr),
    .wr_re_i   (coef_re),
    .wr_im_i   (coef_im),
    .tap_re_o  (tap_re),
    .tap_im_o  (tap_im)
  );

  fir4_window #(.LANES(LANES), .DW(DW), .TAPS(TAPS), .HIST(HIST)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_i    (in_valid),
    .cur_re_i (in_re),
    .cur_im_i (in_im),
    .win_re_o (win_re),
    .win_im_o (win_im)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      fir4_cmul #(.DW(DW), .CW(CW), .PW(PW)) u_mul (
        .a_re_i (win_re[(k*LANES + l)*DW +: DW]),
        .a_im_i (win_im[(k*LANES + l)*DW +: DW]),
        .c_re_i (tap_re[k*CW +: CW]),
        .c_im_i (tap_im[k*CW +: CW]),
        .p_re_o (prod_re_d[(l*TAPS + k)*PW +: PW]),
        .p_im_o (prod_im_d[(l*TAPS + k)*PW +: PW])
      );
    end

    fir4_lane_out #(.TAPS(TAPS), .PW(PW), .DW(DW), .CW(CW)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (s1_valid_q),
      .prod_re_i (prod_re_q[l*TAPS*PW +: TAPS*PW]),
      .prod_im_i (prod_im_q[l*TAPS*PW +: TAPS*PW]),
      .y_re_o    (out_re[l*DW +: DW]),
      .y_im_o    (out_im[l*DW +: DW])
    );
  end

  // Product stage: captured only for accepted vectors.
  always_comb begin
    prod_re_n   = prod_re_q;
    prod_im_n   = prod_im_q;
    s1_valid_n  = in_valid;
    out_valid_n = s1_valid_q;
    if (in_valid) begin
      prod_re_n = prod_re_d;
      prod_im_n = prod_im_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_re_q   <= '0;
      prod_im_q   <= '0;
      s1_valid_q  <= 1'b0;
      out_valid_q <= 1'b0;
    end else begin
      prod_re_q   <= prod_re_n;
      prod_im_q   <= prod_im_n;
      s1_valid_q  <= s1_valid_n;
      out_valid_q <= out_valid_n;
    end
  end

  assign out_valid = out_valid_q;

  // R7: an accepted vector leaves two edges later
  assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  // R7: no output vector without an input two edges earlier
  assert_idle_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

endmodule

// File: tb/test_fir4_vec_filter.sv
module test_fir4_vec_filter;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LANES = 4;
  localparam int DW    = 16;
  localparam int CW    = 16;
  localparam int TAPS  = 8;
  localparam int AW    = 3;
  localparam int MAXS  = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [LANES*DW-1:0] in_re = '0, in_im = '0;
  logic coef_we = 1'b0;
  logic [AW-1:0] coef_addr = '0;
  logic [CW-1:0] coef_re = '0, coef_im = '0;
  logic out_valid;
  logic [LANES*DW-1:0] out_re, out_im;

  always #4 clk = ~clk;

  fir4_vec_filter i_fir4_vec_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_re(coef_re), .coef_im(coef_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;
  string req = "R1";
  int xr [MAXS];
  int xi [MAXS];
  int nsamp = 0;
  int hr [TAPS];
  int hi [TAPS];
  logic [2*LANES*DW-1:0] expq [$];
  logic pipe0 = 1'b0, pipe1 = 1'b0;
  int cyc = 0;

  function automatic int rsat(input longint acc);
    longint r;
    r = (acc + (64'sd1 <<< (CW-2))) >>> (CW-1);
    if (r > 32767) return 32767;
    if (r < -32768) return -32768;
    return int'(r);
  endfunction

  task automatic check(input string r, input bit ok, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic send(input int vr [LANES], input int vi [LANES]);
    logic [LANES*DW-1:0] er, ei;
    for (int l = 0; l < LANES; l++) begin
      xr[nsamp+l] = vr[l];
      xi[nsamp+l] = vi[l];
    end
    for (int l = 0; l < LANES; l++) begin
      longint ar = 0, ai = 0;
      for (int k = 0; k < TAPS; k++) begin
        int idx = nsamp + l - k;
        if (idx >= 0) begin
          ar += longint'(hr[k]) * xr[idx] - longint'(hi[k]) * xi[idx];
          ai += longint'(hr[k]) * xi[idx] + longint'(hi[k]) * xr[idx];
        end
      end
      er[l*DW +: DW] = DW'(rsat(ar));
      ei[l*DW +: DW] = DW'(rsat(ai));
      in_re[l*DW +: DW] = DW'(vr[l]);
      in_im[l*DW +: DW] = DW'(vi[l]);
    end
    nsamp += LANES;
    expq.push_back({ei, er});
    in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wcoef(input int k, input int re, input int im);
    coef_we = 1'b1;
    coef_addr = AW'(k);
    coef_re = CW'(re);
    coef_im = CW'(im);
    hr[k] = re;
    hi[k] = im;
    @(posedge clk); #1;
    coef_we = 1'b0;
  endtask

  task automatic clear_coefs();
    for (int k = 0; k < TAPS; k++) wcoef(k, 0, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Output monitor: R7 timing every cycle, data against the model queue
  always @(negedge clk) begin
    if (!rst_n) begin
      pipe0 <= 1'b0;
      pipe1 <= 1'b0;
    end else if (!done) begin
      check("R7 valid timing", out_valid == pipe1, 128'(out_valid), 128'(pipe1));
      if (out_valid && pipe1) begin
        if (expq.size() == 0) begin
          check({req, " output without expectation"}, 1'b0, {out_im, out_re}, '0);
        end else begin
          logic [2*LANES*DW-1:0] e;
          e = expq.pop_front();
          check({req, " lane data"}, {out_im, out_re} == e, {out_im, out_re}, e);
        end
      end
      pipe1 <= pipe0;
      pipe0 <= in_valid;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL R7 watchdog actual=%0d expected<%0d", cyc, 100000);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < TAPS; k++) begin hr[k] = 0; hi[k] = 0; end
    idle(3);
    rst_n = 1'b1;
    idle(1);
    @(negedge clk);
    // R1: reset state at the ports
    check("R1 reset outputs", !out_valid && out_re == '0 && out_im == '0,
          {out_valid, out_im, out_re}, '0);
    @(posedge clk); #1;

    // R1/R10: only delayed taps written, tap 0 stays zero from reset
    req = "R1 R10 first vector";
    for (int k = 1; k < TAPS; k++) wcoef(k, 3000 * k, -1000 * k);
    send('{1000, 2000, 3000, 4000}, '{-500, 700, -900, 1100});
    idle(4);

    // R2: tap 0 at half gain, lane order
    req = "R2 tap0";
    clear_coefs();
    wcoef(0, 16384, 0);
    send('{100, 200, 300, 400}, '{-10, -20, -30, -40});
    send('{1234, -4321, 8000, -8000}, '{5, 6, 7, 8});
    idle(4);

    // R3: single delay tap across the vector boundary
    req = "R3 tap1";
    clear_coefs();
    wcoef(1, 32767, 0);
    send('{11, 22, 33, 44}, '{1, 2, 3, 4});
    send('{55, 66, 77, 88}, '{5, 6, 7, 8});
    send('{-99, 99, -99, 99}, '{0, 0, 0, 0});
    idle(4);

    // R4: deepest tap reaches two vectors back
    req = "R4 tap7";
    clear_coefs();
    wcoef(TAPS-1, 16384, 0);
    send('{1000, 2000, 3000, 4000}, '{1, 2, 3, 4});
    send('{5000, 6000, 7000, 8000}, '{5, 6, 7, 8});
    send('{9000, 10000, 11000, 12000}, '{9, 10, 11, 12});
    idle(4);

    // R5: complex taps broadcast to all lanes
    req = "R5 complex taps";
    clear_coefs();
    wcoef(0, 12000, -9000);
    wcoef(2, -7000, 15000);
    send('{3000, -2000, 1500, -700}, '{-1200, 2500, 900, -3300});
    send('{800, 6000, -6000, 250}, '{4000, -100, 77, 3210});
    idle(4);

    // R8: rounding ties at half gain
    req = "R8 rounding";
    clear_coefs();
    wcoef(0, 16384, 16384);
    send('{1, -1, 3, -3}, '{0, 0, 0, 0});
    send('{5, -5, 0, 1}, '{1, -1, 2, -2});
    idle(4);

    // R9: saturation in both directions
    req = "R9 saturation";
    for (int k = 0; k < TAPS; k++) wcoef(k, 32767, 0);
    send('{32767, 32767, 32767, 32767}, '{-32768, -32768, -32768, -32768});
    send('{32767, 32767, 32767, 32767}, '{-32768, -32768, -32768, -32768});
    send('{-32768, -32768, -32768, -32768}, '{32767, 32767, 32767, 32767});
    send('{-32768, -32768, -32768, -32768}, '{32767, 32767, 32767, 32767});
    idle(4);

    // R6 with R3/R4/R5: random taps and data, random idle gaps
    req = "R6 random gaps";
    for (int blk = 0; blk < 4; blk++) begin
      for (int k = 0; k < TAPS; k++)
        wcoef(k, int'($signed(16'($urandom))) >>> (blk % 3), int'($signed(16'($urandom))) >>> 2);
      for (int v = 0; v < 60; v++) begin
        int vr [LANES];
        int vi [LANES];
        for (int l = 0; l < LANES; l++) begin
          vr[l] = int'($signed(16'($urandom))) >>> ($urandom % 4);
          vi[l] = int'($signed(16'($urandom))) >>> ($urandom % 4);
        end
        send(vr, vi);
        idle(int'($urandom % 4));
      end
      idle(4);
    end

    idle(4);
    check("R7 all expected outputs seen", expq.size() == 0, 128'(expq.size()), '0);
    done = 1'b1;
    summary();
  end

endmodule